// File: doc/BRIEF.md
# Serial-Load FFT Frame Loader

This block sits in front of a transform engine that wants a whole frame of complex samples at once but is fed through a narrow port. Samples arrive one 16-bit word per clock, each a signed fixed-point value with 8 integer bits and 8 fraction bits (a step of 2^-8). A point index and a real/imaginary selector steer each word into an internal bank of 32 complex points, held as 64 separate words, so the pin count stays small.

Once the frame is loaded, a start pulse copies the bank onto a wide parallel output bus and raises a request toward the downstream engine. The request follows a four-phase push handshake. It stays high until the acknowledge is seen, and the controller then waits for the acknowledge to fall before it accepts new work. The bus holds the frame for the whole exchange. A global enable gates all activity, and dropping it aborts any exchange.

Top module: `fft_frame_loader`

## Requirements
- R1: After reset the request is low and every word of the output bus is zero.
- R2: While idle with both enables high, a clock edge stores the input word at bank word 2*point+part (part 0 = real, 1 = imaginary). After the next start that word appears on output bits [16*w+15 : 16*w].
- R3: A word offered while either the global enable or the load enable is low is not stored.
- R4: Start sampled high while idle with the global enable high makes the request high and loads the whole bank onto the bus at the same clock edge.
- R5: The request stays high until the acknowledge is sampled high. It is low from the following edge.
- R6: The output bus does not change from the rise of the request until the controller is idle again.
- R7: Writes offered while a transfer is active (request high, or acknowledge not yet fallen) are ignored.
- R8: Start offered while a transfer is active is ignored.
- R9: Global enable sampled low forces the request low at the next edge and returns the controller to idle.
- R10: After the acknowledge falls the controller is idle, and a further start begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en_i | input | 1 | Global enable; held high through the whole operation |
| ld_en_i | input | 1 | Load enable for word writes |
| sel_i | input | 5 | Point index of the word being written |
| im_i | input | 1 | 0 = real part, 1 = imaginary part |
| din_i | input | 16 | Sample word, signed 8.8 fixed point |
| start_i | input | 1 | Begin a transfer of the loaded frame |
| ack_i | input | 1 | Acknowledge from the downstream block |
| req_o | output | 1 | Request to the downstream block |
| frame_o | output | 1024 | Parallel frame, word w at bits [16*w+15 : 16*w] |

## Verification
On every cycle the assertions check the handshake rules: the request holds without an acknowledge, it drops after one, it falls when the enable goes away, and it rises only after a start. They also check that the bus and the bank stay frozen while a transfer is active. Only the bench scenarios can show that every one of the 64 word addresses lands in the right bus slot with the right value. The same holds for writes blocked by either enable and for writes or starts offered mid-transfer that leave no trace in the next frame.

// File: rtl/fl_pkg.sv
package fl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_DRAIN = 2'd2
  } fl_state_t;
endpackage

// File: rtl/fl_bank.sv
module fl_bank #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busy_i,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [WORDS*WORD_W-1:0] flat_o
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_flat
    assign flat_o[g*WORD_W +: WORD_W] = mem[g];
  end

  // R7: bank contents frozen while a transfer is active
  a_r7_bank_frozen: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(flat_o));
endmodule

// File: rtl/fl_ctrl.sv
module fl_ctrl
  import fl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic glb_en_i,
  input  logic start_i,
  input  logic ack_i,
  output logic capture_o,
  output logic busy_o,
  output logic req_o
);
  fl_state_t st;

  assign busy_o    = (st != ST_IDLE);
  assign capture_o = glb_en_i && start_i && (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !glb_en_i) begin
      st    <= ST_IDLE;
      req_o <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_i) begin
          st    <= ST_REQ;
          req_o <= 1'b1;
        end
        ST_REQ: if (ack_i) begin
          st    <= ST_DRAIN;
          req_o <= 1'b0;
        end
        ST_DRAIN: if (!ack_i) st <= ST_IDLE;
        default: begin
          st    <= ST_IDLE;
          req_o <= 1'b0;
        end
      endcase
    end
  end

  a_r5_req_holds: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i && glb_en_i) |=> req_o);
  a_r5_req_drops: assert property (@(posedge clk) disable iff (rst)
    (req_o && ack_i) |=> !req_o);
  a_r9_enable_abort: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> (!req_o && !busy_o));
  a_r4_req_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(start_i));
endmodule

// File: rtl/fl_frame_reg.sv
module fl_frame_reg #(
  parameter int BUS_W = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_i,
  input  logic [BUS_W-1:0] d_i,
  output logic [BUS_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/fft_frame_loader.sv
module fft_frame_loader #(
  parameter int SAMPLE_W = 16,
  parameter int POINTS   = 32,
  localparam int PT_W  = $clog2(POINTS),
  localparam int WORDS = 2 * POINTS,
  localparam int WA_W  = PT_W + 1,
  localparam int BUS_W = WORDS * SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                glb_en_i,
  input  logic                ld_en_i,
  input  logic [PT_W-1:0]     sel_i,
  input  logic                im_i,
  input  logic [SAMPLE_W-1:0] din_i,
  input  logic                start_i,
  input  logic                ack_i,
  output logic                req_o,
  output logic [BUS_W-1:0]    frame_o
);
  logic            busy, capture, we;
  logic [WA_W-1:0] waddr;
  logic [BUS_W-1:0] bank_flat;

  assign we    = glb_en_i && ld_en_i && !busy;
  assign waddr = {sel_i, im_i};

  fl_ctrl u_ctrl (
    .clk(clk), .rst(rst), .glb_en_i(glb_en_i), .start_i(start_i),
    .ack_i(ack_i), .capture_o(capture), .busy_o(busy), .req_o(req_o)
  );

  fl_bank #(.WORD_W(SAMPLE_W), .WORDS(WORDS)) u_bank (
    .clk(clk), .rst(rst), .busy_i(busy), .we_i(we), .waddr_i(waddr),
    .wdata_i(din_i), .flat_o(bank_flat)
  );

  fl_frame_reg #(.BUS_W(BUS_W)) u_frame (
    .clk(clk), .rst(rst), .cap_i(capture), .d_i(bank_flat), .q_o(frame_o)
  );

  // R6: frame frozen while the handshake is in progress
  a_r6_bus_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(frame_o));
  // R4: a rising request carries a freshly captured frame
  a_r4_frame_matches: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> (frame_o == $past(bank_flat)));
endmodule

// File: tb/test_fft_frame_loader.sv
module test_fft_frame_loader;
  localparam int W = 16, NW = 64;
  logic clk = 1'b0, rst = 1'b1, glb = 1'b0, ld = 1'b0, im = 1'b0;
  logic start = 1'b0, ack = 1'b0;
  logic [4:0] sel = '0;
  logic [W-1:0] din = '0;
  logic req;
  logic [NW*W-1:0] frame;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fft_frame_loader i_fft_frame_loader (
    .clk(clk), .rst(rst), .glb_en_i(glb), .ld_en_i(ld), .sel_i(sel),
    .im_i(im), .din_i(din), .start_i(start), .ack_i(ack),
    .req_o(req), .frame_o(frame)
  );

  function automatic logic [W-1:0] pat_a(int w);
    logic [W-1:0] v;
    v = W'(w * 16'h0913 + 16'h3A05) ^ W'(w << 9);
    if (w == 0)  v = 16'h8000;
    if (w == 63) v = 16'h7FFF;
    return v;
  endfunction

  function automatic logic [W-1:0] pat_b(int w);
    return ~pat_a(w);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word(int w);
    return frame[w*W +: W];
  endfunction

  task automatic wr(input int w, input logic [W-1:0] d, input bit g, input bit l);
    @(negedge clk);
    sel = 5'(w >> 1); im = w[0]; din = d; glb = g; ld = l;
    @(negedge clk);
    ld = 1'b0; glb = 1'b1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] snap5;
    bit allz;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    allz = (frame == '0);
    chk(req == 1'b0, "R1 req after reset", W'(req), 0);
    chk(allz, "R1 bus zero after reset", word(0), 0);

    // R2: load every word, pattern A
    glb = 1'b1;
    for (int w = 0; w < NW; w++) wr(w, pat_a(w), 1'b1, 1'b1);
    chk(req == 1'b0, "R4 no req before start", W'(req), 0);
    pulse_start();
    chk(req == 1'b1, "R4 req after start", W'(req), 1);
    for (int w = 0; w < NW; w++) chk(word(w) == pat_a(w), "R2 word after load A", word(w), pat_a(w));

    // R5/R6: hold without ack; R7 write during REQ
    snap5 = word(5);
    wr(5, pat_b(5), 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    chk(req == 1'b1, "R5 req held without ack", W'(req), 1);
    chk(word(5) == snap5, "R6 bus stable during req", word(5), snap5);
    @(negedge clk); ack = 1'b1;
    @(negedge clk);
    chk(req == 1'b0, "R5 req dropped after ack", W'(req), 0);
    // R7/R8 while acknowledge still high
    wr(9, pat_b(9), 1'b1, 1'b1);
    pulse_start();
    chk(req == 1'b0, "R8 start ignored during drain", W'(req), 0);
    chk(word(9) == pat_a(9), "R6 bus stable during drain", word(9), pat_a(9));
    @(negedge clk); ack = 1'b0;
    @(negedge clk);

    // R3: blocked writes to words 3 and 7
    wr(3, pat_b(3), 1'b1, 1'b0);
    wr(7, pat_b(7), 1'b0, 1'b1);
    for (int w = 0; w < NW; w += 2) wr(w, pat_b(w), 1'b1, 1'b1);
    pulse_start();  // R10: new transfer after idle
    chk(req == 1'b1, "R10 new transfer after ack fell", W'(req), 1);
    for (int w = 0; w < NW; w++) begin
      logic [W-1:0] e;
      e = w[0] ? pat_a(w) : pat_b(w);
      chk(word(w) == e, "R2 word after load B", word(w), e);
    end
    chk(word(3) == pat_a(3), "R3 load enable low blocks write", word(3), pat_a(3));
    chk(word(7) == pat_a(7), "R3 global enable low blocks write", word(7), pat_a(7));
    chk(word(5) == pat_a(5), "R7 write during req ignored", word(5), pat_a(5));
    chk(word(9) == pat_a(9), "R7 write during drain ignored", word(9), pat_a(9));

    // R9: drop global enable with request high
    @(negedge clk); glb = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R9 enable low drops req", W'(req), 0);
    glb = 1'b1;
    @(negedge clk);
    chk(req == 1'b0, "R9 stays idle after enable returns", W'(req), 0);
    wr(1, 16'h0123, 1'b1, 1'b1);
    pulse_start();
    chk(req == 1'b1, "R9 idle after abort accepts start", W'(req), 1);
    chk(word(1) == 16'h0123, "R9 idle after abort accepts writes", word(1), 16'h0123);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    @(negedge clk);
    chk(req == 1'b0, "R10 handshake complete", W'(req), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule